// File: doc/BRIEF.md
# Limited Face Reconstruction Unit

This block rebuilds second-order face states for a finite-volume flow solver. For every cell face it receives four primitive quantities (density, u, v and pressure) from the four cells that straddle the face in one row: two cells to the left (far and near) and two to the right (near and far). From these it forms three slopes and limits each side's slope with a minmod rule. It returns the left and right face values, each extrapolated by half of the limited slope from its own cell.

The unit accepts one face per clock and is fully pipelined. It has a fixed latency of two cycles, and a valid flag travels with the data. All arithmetic is signed fixed point of width `W`. Slopes are carried with one extra bit so that they cannot overflow. The four primitives go through identical, independent lanes.

Top module: `minmod_face_recon`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted face arrives, `out_valid` is 0 and both face buses are all zeros.
- R2: A face accepted with `in_valid` high at one rising edge appears with `out_valid` high after the second rising edge. `out_valid` is low two edges after any edge at which `in_valid` was low.
- R3: Per lane, the slopes are sL = P_L − P_LL, sC = P_R − P_L and sR = P_RR − P_R, formed without overflow. The left face value is P_L + floor(gL/2), where gL is the limited left slope.
- R4: When sL and sC are both nonzero with the same sign and their magnitudes differ, gL is whichever of the two has the smaller magnitude.
- R5: When sL and sC are nonzero with the same sign and equal magnitude, gL equals sC.
- R6: When sL or sC is zero, or the two have opposite signs, gL is 0, so the left face value equals P_L.
- R7: The right face value is P_R − floor(gR/2). gR follows the rules of R4 to R6 applied to the pair (sR, sC), with sC chosen on equal magnitude.
- R8: Each bus packs four W-bit two's-complement lanes, with lane k at bits [k·W +: W]. The lanes are 0 density, 1 u, 2 v and 3 pressure. Each lane depends only on its own inputs.
- R9: Input values presented with `in_valid` low have no effect, and the face buses hold their last values while `out_valid` is low.
- R10: Every face value lies within the closed range spanned by P_L and P_R of the same lane, so it always fits in W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A face is presented on the input buses |
| in_ll | input | 4·W | Far-left cell primitives, four lanes |
| in_l | input | 4·W | Near-left cell primitives, four lanes |
| in_r | input | 4·W | Near-right cell primitives, four lanes |
| in_rr | input | 4·W | Far-right cell primitives, four lanes |
| out_valid | output | 1 | Face buses carry a new result |
| out_left | output | 4·W | Limited left face state, four lanes |
| out_right | output | 4·W | Limited right face state, four lanes |

## Verification
A corrupted slope register, or a wrong choice inside a limiter, shows up as a face value that differs from the arithmetic model on the face it belongs to, exactly two edges after that face was accepted. The sweep covers every sign and magnitude pattern of four cells over a small value range, so any such error is visible within one pass. A broken valid stage or load enable shows up on the same cycle, either as a misplaced `out_valid` or as face buses that change during idle cycles. Overflow in slope formation shows up only on a lane driven near full scale, as a value outside the P_L to P_R range.

// File: rtl/recon_pkg.sv
package recon_pkg;
    // number of primitive quantities handled side by side
    localparam int RECON_NPRIM = 4;
    // lane order on every packed bus
    localparam int LANE_RHO = 0;
    localparam int LANE_U   = 1;
    localparam int LANE_V   = 2;
    localparam int LANE_P   = 3;
endpackage

// File: rtl/slope_minmod.sv
// Minmod choice between an outer slope and the centre slope.
module slope_minmod #(
    parameter int DW = 17
) (
    input  logic signed [DW-1:0] outer,
    input  logic signed [DW-1:0] centre,
    output logic signed [DW-1:0] pick
);
    logic          zero_o, zero_c, agree;
    logic [DW-1:0] mag_o, mag_c;

    always_comb begin
        zero_o = (outer == '0);
        zero_c = (centre == '0);
        agree  = !zero_o && !zero_c && (outer[DW-1] == centre[DW-1]);
        mag_o  = outer[DW-1]  ? (~outer + 1'b1)  : outer;
        mag_c  = centre[DW-1] ? (~centre + 1'b1) : centre;
        if (!agree)
            pick = '0;
        else if (mag_o < mag_c)
            pick = outer;
        else
            pick = centre;
    end
endmodule

// File: rtl/recon_lane.sv
// One primitive quantity: slope stage, then limit and extrapolate stage.
module recon_lane #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_slope,
    input  logic                ld_face,
    input  logic signed [W-1:0] p_ll,
    input  logic signed [W-1:0] p_l,
    input  logic signed [W-1:0] p_r,
    input  logic signed [W-1:0] p_rr,
    output logic signed [W-1:0] face_l,
    output logic signed [W-1:0] face_r
);
    localparam int DW = W + 1;

    logic signed [DW-1:0] s_lo_q, s_mid_q, s_hi_q;
    logic signed [W-1:0]  base_l_q, base_r_q;
    logic signed [DW-1:0] g_l, g_r, half_l, half_r;
    logic        [DW-1:0] sum_l, sum_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_lo_q   <= '0;
            s_mid_q  <= '0;
            s_hi_q   <= '0;
            base_l_q <= '0;
            base_r_q <= '0;
        end else if (ld_slope) begin
            s_lo_q   <= {p_l[W-1], p_l}   - {p_ll[W-1], p_ll};
            s_mid_q  <= {p_r[W-1], p_r}   - {p_l[W-1], p_l};
            s_hi_q   <= {p_rr[W-1], p_rr} - {p_r[W-1], p_r};
            base_l_q <= p_l;
            base_r_q <= p_r;
        end
    end

    slope_minmod #(.DW(DW)) u_lim_left (
        .outer (s_lo_q),
        .centre(s_mid_q),
        .pick  (g_l)
    );

    slope_minmod #(.DW(DW)) u_lim_right (
        .outer (s_hi_q),
        .centre(s_mid_q),
        .pick  (g_r)
    );

    always_comb begin
        half_l = g_l >>> 1;
        half_r = g_r >>> 1;
        sum_l  = {base_l_q[W-1], base_l_q} + half_l;
        sum_r  = {base_r_q[W-1], base_r_q} - half_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            face_l <= '0;
            face_r <= '0;
        end else if (ld_face) begin
            face_l <= sum_l[W-1:0];
            face_r <= sum_r[W-1:0];
        end
    end
endmodule

// File: rtl/minmod_face_recon.sv
module minmod_face_recon
    import recon_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [RECON_NPRIM*W-1:0]   in_ll,
    input  logic [RECON_NPRIM*W-1:0]   in_l,
    input  logic [RECON_NPRIM*W-1:0]   in_r,
    input  logic [RECON_NPRIM*W-1:0]   in_rr,
    output logic                       out_valid,
    output logic [RECON_NPRIM*W-1:0]   out_left,
    output logic [RECON_NPRIM*W-1:0]   out_right
);
    logic slope_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slope_vld_q <= 1'b0;
            out_valid   <= 1'b0;
        end else begin
            slope_vld_q <= in_valid;
            out_valid   <= slope_vld_q;
        end
    end

    for (genvar k = 0; k < RECON_NPRIM; k++) begin : g_lane
        logic signed [W-1:0] fl, fr;

        recon_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_slope(in_valid),
            .ld_face (slope_vld_q),
            .p_ll    (in_ll[k*W +: W]),
            .p_l     (in_l[k*W +: W]),
            .p_r     (in_r[k*W +: W]),
            .p_rr    (in_rr[k*W +: W]),
            .face_l  (fl),
            .face_r  (fr)
        );

        assign out_left[k*W +: W]  = fl;
        assign out_right[k*W +: W] = fr;
    end
endmodule

// File: rtl/minmod_face_recon_chk.sv
module minmod_face_recon_chk
    import recon_pkg::*;
#(
    parameter int W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [RECON_NPRIM*W-1:0] in_l,
    input logic [RECON_NPRIM*W-1:0] in_r,
    input logic                     out_valid,
    input logic [RECON_NPRIM*W-1:0] out_left,
    input logic [RECON_NPRIM*W-1:0] out_right
);
    logic [RECON_NPRIM*W-1:0] l_d1, l_d2, r_d1, r_d2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_d1 <= '0;
            l_d2 <= '0;
            r_d1 <= '0;
            r_d2 <= '0;
        end else begin
            l_d1 <= in_l;
            l_d2 <= l_d1;
            r_d1 <= in_r;
            r_d2 <= r_d1;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);                                   // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);                                 // R2
    AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_left));                             // R9
    AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_right));                            // R9

    for (genvar k = 0; k < RECON_NPRIM; k++) begin : g_bound
        logic signed [W-1:0] pl, pr, lo, hi, fl, fr;
        always_comb begin
            pl = l_d2[k*W +: W];
            pr = r_d2[k*W +: W];
            lo = (pl < pr) ? pl : pr;
            hi = (pl < pr) ? pr : pl;
            fl = out_left[k*W +: W];
            fr = out_right[k*W +: W];
        end
        AST_LEFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (lo <= fl) && (fl <= hi));                   // R10
        AST_RIGHT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (lo <= fr) && (fr <= hi));                   // R10
    end
endmodule

bind minmod_face_recon minmod_face_recon_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_l     (in_l),
    .in_r     (in_r),
    .out_valid(out_valid),
    .out_left (out_left),
    .out_right(out_right)
);

// File: tb/minmod_face_recon_tb_top.sv
module minmod_face_recon_tb_top;
    localparam int W = 16;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_ll = '0, in_l = '0, in_r = '0, in_rr = '0;
    logic           out_valid;
    logic [N*W-1:0] out_left, out_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    minmod_face_recon #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_ll(in_ll), .in_l(in_l), .in_r(in_r), .in_rr(in_rr),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    // two-deep history of what was driven; index 1 is due at the next check
    bit             h_vld [2];
    logic [N*W-1:0] h_left [2], h_right [2], h_pl [2], h_pr [2];
    int             h_cls [2][N];
    logic [N*W-1:0] held_left = '0, held_right = '0;

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // 0: disagree or zero, 1: equal magnitude, 2: smaller picked
    function automatic int classify(input int o, input int c);
        if (o == 0 || c == 0 || ((o < 0) != (c < 0))) return 0;
        if (iabs(o) == iabs(c)) return 1;
        return 2;
    endfunction

    function automatic int limit(input int o, input int c);
        int cl;
        cl = classify(o, c);
        if (cl == 0) return 0;
        if (iabs(o) < iabs(c)) return o;
        return c;
    endfunction

    task automatic note(input bit ok, input string tag, input int lane,
                        input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s lane %0d actual %0d expected %0d", tag, lane, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [N*W-1:0] el, er;
        string base;
        if (h_vld[1]) begin
            el = h_left[1];
            er = h_right[1];
        end else begin
            el = held_left;
            er = held_right;
        end
        note(out_valid == h_vld[1], "R2", 0, int'(out_valid), int'(h_vld[1]));
        for (int k = 0; k < N; k++) begin
            int al, ar, xl, xr, pl, pr;
            al = int'($signed(out_left[k*W +: W]));
            ar = int'($signed(out_right[k*W +: W]));
            xl = int'($signed(el[k*W +: W]));
            xr = int'($signed(er[k*W +: W]));
            if (!h_vld[1]) begin
                base = "R1 R9";
                note(al == xl, base, k, al, xl);
                note(ar == xr, base, k, ar, xr);
            end else begin
                case (h_cls[1][k])
                    0: base = "R3 R6";
                    1: base = "R3 R5";
                    default: base = "R3 R4";
                endcase
                if (k != 0) base = {base, " R8"};
                note(al == xl, base, k, al, xl);
                note(ar == xr, (k != 0) ? "R7 R8" : "R7", k, ar, xr);
                pl = int'($signed(h_pl[1][k*W +: W]));
                pr = int'($signed(h_pr[1][k*W +: W]));
                note((al >= ((pl < pr) ? pl : pr)) && (al <= ((pl < pr) ? pr : pl)),
                     "R10", k, al, pl);
                note((ar >= ((pl < pr) ? pl : pr)) && (ar <= ((pl < pr) ? pr : pl)),
                     "R10", k, ar, pr);
            end
        end
        if (h_vld[1]) begin
            held_left  = h_left[1];
            held_right = h_right[1];
        end
    endtask

    // one cycle: check, shift history, drive new face; v[k] = {ll, l, r, rr}
    task automatic step(input bit vld, input int v [N][4]);
        @(negedge clk);
        check_outputs();
        h_vld[1]   = h_vld[0];
        h_left[1]  = h_left[0];
        h_right[1] = h_right[0];
        h_pl[1]    = h_pl[0];
        h_pr[1]    = h_pr[0];
        h_cls[1]   = h_cls[0];
        h_vld[0]   = vld;
        for (int k = 0; k < N; k++) begin
            int sl, sc, sr, gl, gr;
            logic [W-1:0] fl, fr;
            sl = v[k][1] - v[k][0];
            sc = v[k][2] - v[k][1];
            sr = v[k][3] - v[k][2];
            gl = limit(sl, sc);
            gr = limit(sr, sc);
            fl = W'(v[k][1] + (gl >>> 1));
            fr = W'(v[k][2] - (gr >>> 1));
            h_left[0][k*W +: W]  = fl;
            h_right[0][k*W +: W] = fr;
            h_pl[0][k*W +: W]    = W'(v[k][1]);
            h_pr[0][k*W +: W]    = W'(v[k][2]);
            h_cls[0][k]          = classify(sl, sc);
            in_ll[k*W +: W] = W'(v[k][0]);
            in_l[k*W +: W]  = W'(v[k][1]);
            in_r[k*W +: W]  = W'(v[k][2]);
            in_rr[k*W +: W] = W'(v[k][3]);
        end
        in_valid = vld;
    endtask

    initial begin
        int v [N][4];
        for (int i = 0; i < 2; i++) begin
            h_vld[i] = 0; h_left[i] = '0; h_right[i] = '0;
            h_pl[i] = '0; h_pr[i] = '0;
            for (int k = 0; k < N; k++) h_cls[i][k] = 0;
        end
        repeat (3) @(negedge clk);
        check_outputs();                       // R1 during reset
        rst_n = 1'b1;
        for (int k = 0; k < N; k++) for (int j = 0; j < 4; j++) v[k][j] = 0;
        step(0, v);
        step(0, v);
        // sweep of four cells over -3..3 on each lane pattern
        for (int a = -3; a <= 3; a++)
            for (int b = -3; b <= 3; b++)
                for (int c = -3; c <= 3; c++)
                    for (int d = -3; d <= 3; d++) begin
                        v[0] = '{a, b, c, d};
                        v[1] = '{d, c, b, a};
                        v[2] = '{a * 7000, b * 7000, c * 7000, d * 7000};
                        v[3] = '{b * 3, -c, d * 5, -a};
                        step(1, v);
                    end
        // idle with changing inputs: no effect, outputs hold (R9)
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k < N; k++) v[k] = '{i * 11 - 30, -i * 5, 1000 + i, -777};
            step(0, v);
        end
        // full-scale corners (R3, R10)
        v[0] = '{-32768, 32767, -32768, 32767};
        v[1] = '{-32768, 0, 32767, 32767};
        v[2] = '{32767, -32768, -32768, 32767};
        v[3] = '{-32768, -100, 32767, 32767};
        step(1, v);
        v[0] = '{32767, 0, -32768, -32768};
        v[1] = '{0, 1, 2, 3};
        v[2] = '{3, 2, 1, 0};
        v[3] = '{-32768, -32768, 32767, 32767};
        step(1, v);
        for (int k = 0; k < N; k++) v[k] = '{5, 5, 5, 5};
        for (int i = 0; i < 4; i++) step(0, v);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule